// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block sits between instruction fetch and execute. It takes one 32-bit fetched word at a time and decides how its contents reach execute. The top two bits of the word pick the format. The word is either one long operation, or two 15-bit short operations. Two short operations issue in a fixed order or as a parallel pair, and in a pair one side can act as a condition test that guards the other side.

Each issue is a one-cycle strobe. It carries the payload, a 6-bit opcode class and a slot tag. When a word holds two short operations, the block issues the first one and then waits for feedback from execute: a PC change, an exception, or a condition result. It then either issues the partner or drops it. While it waits it lowers its ready output, which stalls fetch. A cycle counter advances once for each accepted word, and once more when the second operation of an ordered pair issues.

A parameter mask lists the short opcode classes that are condition-test-only. Opcode semantics, registers and memory belong to other blocks.

Top module: `issue_sequencer`

## Requirements
- R1: A word whose bits 31:30 are 11 issues a single strobe with tag LONG (code 0), payload = bits 29:0 and class = bits 29:24. The ready output stays high.
- R2: The left short operation is bits 29:15 and the right short operation is bits 14:0. A short issue carries the 15-bit operation zero-extended to 30 bits, and its class is bits 14:9 of that operation.
- R3: Format 01 issues the left operation with tag LEFT (code 1). After feedback with no PC change and no exception, it issues the right operation with tag RIGHT (code 2).
- R4: Format 10 issues the right operation first with tag RIGHT, and then the left operation with tag LEFT, under the same feedback rule as R3.
- R5: In formats 01 and 10 the second operation is dropped if the feedback reports a PC change or an exception. A PC change without an exception also raises the jump-skip strobe (a taken-jump event) for one cycle.
- R6: In format 00, if the left class is in the condition-test mask, the left operation issues first with tag CTEST (code 3). The right operation then issues with tag CEXEC (code 4) only if the feedback condition is true. The left side wins when both classes are in the mask.
- R7: In format 00, if only the right class is in the mask, the right operation issues with tag CTEST and the left operation issues with tag CEXEC only if the condition is true.
- R8: In format 00 with neither class in the mask, the left operation issues with tag LEFT. The right operation then issues with tag RIGHT unless the feedback reports an exception; a PC change does not drop it.
- R9: The cycle counter rises by one on each accepted word, and by one more when the second operation of a format 01 or 10 word issues. The second issue of a format 00 pair does not count.
- R10: Ready is low from the acceptance of any two-operation word until its feedback is taken. Words offered while ready is low are not accepted, and feedback that arrives while no pair is pending has no effect.
- R11: After reset, ready is high, no strobe is active and the counter reads zero.
- R12: Every output is registered. The first issue of a word appears in the cycle after the accepting clock edge. The second issue, or the jump-skip strobe, appears in the cycle after the edge that samples the feedback valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Fetched word offered |
| word_ready | output | 1 | Sequencer can accept a word |
| word_data | input | 32 | Fetched instruction word |
| fb_valid | input | 1 | Execute feedback for the pending first operation |
| fb_pc_changed | input | 1 | First operation redirected the PC |
| fb_exception | input | 1 | First operation raised an exception |
| fb_cond_true | input | 1 | Condition-test result |
| iss_valid | output | 1 | One-cycle issue strobe |
| iss_tag | output | 3 | Slot tag: 0 LONG, 1 LEFT, 2 RIGHT, 3 CTEST, 4 CEXEC |
| iss_payload | output | 30 | Issued operation bits |
| iss_class | output | 6 | Opcode class of the issued operation |
| jump_skip | output | 1 | Second operation dropped by a taken jump |
| cyc_count | output | CNT_W | Issue cycle counter |

## Verification
The first strobe of a word is due one clock edge after the word is accepted. The partner strobe, or the jump-skip pulse, is due one edge after the feedback is sampled, and the counter moves on those same edges. The bench drives the word and the feedback on falling edges and holds each for exactly one rising edge. It reads the outputs on the following falling edge, so every check falls in the cycle where R12 places the result. It then looks one more cycle ahead to confirm that the strobe has dropped and that no word offered during a stall was taken.

// File: rtl/isq_pkg.sv
package isq_pkg;

    localparam int WORD_W  = 32;
    localparam int LONG_W  = 30;
    localparam int SHORT_W = 15;
    localparam int CLASS_W = 6;
    localparam int MAP_W   = 2 ** CLASS_W;

    typedef enum logic [1:0] {
        FMT_PAR  = 2'b00,
        FMT_LR   = 2'b01,
        FMT_RL   = 2'b10,
        FMT_LONG = 2'b11
    } word_fmt_e;

    typedef enum logic [2:0] {
        TAG_LONG  = 3'd0,
        TAG_LEFT  = 3'd1,
        TAG_RIGHT = 3'd2,
        TAG_CTEST = 3'd3,
        TAG_CEXEC = 3'd4
    } slot_tag_e;

    typedef enum logic [1:0] {
        PAIR_SEQ  = 2'd0,
        PAIR_COND = 2'd1,
        PAIR_PAR  = 2'd2
    } pair_mode_e;

    typedef struct packed {
        logic                busy;
        pair_mode_e          mode;
        logic [SHORT_W-1:0]  hold_op;
        slot_tag_e           hold_tag;
        logic                out_valid;
        slot_tag_e           out_tag;
        logic [LONG_W-1:0]   out_payload;
        logic [CLASS_W-1:0]  out_class;
        logic                out_skip;
    } seq_state_t;

endpackage

// File: rtl/isq_word_split.sv
module isq_word_split
    import isq_pkg::*;
(
    input  logic [WORD_W-1:0]               word,
    output word_fmt_e                       fmt,
    output logic [LONG_W-1:0]               long_op,
    output logic [CLASS_W-1:0]              long_class,
    output logic [1:0][SHORT_W-1:0]         short_op,
    output logic [1:0][CLASS_W-1:0]         short_class
);
    localparam int LEFT_LO  = SHORT_W;
    localparam int CLASS_LO = SHORT_W - CLASS_W;

    always_comb begin
        fmt        = word_fmt_e'(word[WORD_W-1 -: 2]);
        long_op    = word[LONG_W-1:0];
        long_class = word[LONG_W-1 -: CLASS_W];
        // index 0: left slot, index 1: right slot
        short_op[0] = word[LEFT_LO +: SHORT_W];
        short_op[1] = word[0 +: SHORT_W];
        for (int s = 0; s < 2; s++) begin
            short_class[s] = short_op[s][CLASS_LO +: CLASS_W];
        end
    end

endmodule

// File: rtl/isq_class_lookup.sv
module isq_class_lookup
    import isq_pkg::*;
#(
    parameter logic [MAP_W-1:0] TEST_MAP = '0
) (
    input  logic [CLASS_W-1:0] op_class,
    output logic               test_only
);
    always_comb begin
        test_only = TEST_MAP[op_class];
    end

endmodule

// File: rtl/isq_cycle_counter.sv
module isq_cycle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (step) begin
            count_d = count_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == $past(count_q)) || (count_q == $past(count_q) + ONE));

endmodule

// File: rtl/issue_sequencer.sv
module issue_sequencer
    import isq_pkg::*;
#(
    parameter int               CNT_W     = 16,
    parameter logic [MAP_W-1:0] CTEST_MAP = 64'h0C00_0000_0000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    output logic                word_ready,
    input  logic [31:0]         word_data,
    input  logic                fb_valid,
    input  logic                fb_pc_changed,
    input  logic                fb_exception,
    input  logic                fb_cond_true,
    output logic                iss_valid,
    output logic [2:0]          iss_tag,
    output logic [29:0]         iss_payload,
    output logic [5:0]          iss_class,
    output logic                jump_skip,
    output logic [CNT_W-1:0]    cyc_count
);
    localparam int PAD_W    = LONG_W - SHORT_W;
    localparam int CLASS_LO = SHORT_W - CLASS_W;
    localparam int SLOT_L   = 0;
    localparam int SLOT_R   = 1;

    word_fmt_e                   fmt;
    logic [LONG_W-1:0]           long_op;
    logic [CLASS_W-1:0]          long_class;
    logic [1:0][SHORT_W-1:0]     short_op;
    logic [1:0][CLASS_W-1:0]     short_class;
    logic [1:0]                  ctest_hit;
    logic                        accept;
    logic                        cnt_step;
    seq_state_t                  st_d, st_q;

    isq_word_split u_split (
        .word        (word_data),
        .fmt         (fmt),
        .long_op     (long_op),
        .long_class  (long_class),
        .short_op    (short_op),
        .short_class (short_class)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lookup
        isq_class_lookup #(.TEST_MAP(CTEST_MAP)) u_lookup (
            .op_class  (short_class[g]),
            .test_only (ctest_hit[g])
        );
    end

    isq_cycle_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cnt_step),
        .count (cyc_count)
    );

    assign accept = word_valid && !st_q.busy;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.out_skip  = 1'b0;
        cnt_step       = 1'b0;

        if (accept) begin
            cnt_step = 1'b1;
            unique case (fmt)
                FMT_LONG: begin
                    st_d.out_valid   = 1'b1;
                    st_d.out_tag     = TAG_LONG;
                    st_d.out_payload = long_op;
                    st_d.out_class   = long_class;
                end
                FMT_LR: begin
                    st_d.out_valid   = 1'b1;
                    st_d.out_tag     = TAG_LEFT;
                    st_d.out_payload = {{PAD_W{1'b0}}, short_op[SLOT_L]};
                    st_d.out_class   = short_class[SLOT_L];
                    st_d.busy        = 1'b1;
                    st_d.mode        = PAIR_SEQ;
                    st_d.hold_op     = short_op[SLOT_R];
                    st_d.hold_tag    = TAG_RIGHT;
                end
                FMT_RL: begin
                    st_d.out_valid   = 1'b1;
                    st_d.out_tag     = TAG_RIGHT;
                    st_d.out_payload = {{PAD_W{1'b0}}, short_op[SLOT_R]};
                    st_d.out_class   = short_class[SLOT_R];
                    st_d.busy        = 1'b1;
                    st_d.mode        = PAIR_SEQ;
                    st_d.hold_op     = short_op[SLOT_L];
                    st_d.hold_tag    = TAG_LEFT;
                end
                default: begin
                    st_d.out_valid = 1'b1;
                    st_d.busy      = 1'b1;
                    if (ctest_hit[SLOT_L]) begin
                        st_d.out_tag     = TAG_CTEST;
                        st_d.out_payload = {{PAD_W{1'b0}}, short_op[SLOT_L]};
                        st_d.out_class   = short_class[SLOT_L];
                        st_d.mode        = PAIR_COND;
                        st_d.hold_op     = short_op[SLOT_R];
                        st_d.hold_tag    = TAG_CEXEC;
                    end else if (ctest_hit[SLOT_R]) begin
                        st_d.out_tag     = TAG_CTEST;
                        st_d.out_payload = {{PAD_W{1'b0}}, short_op[SLOT_R]};
                        st_d.out_class   = short_class[SLOT_R];
                        st_d.mode        = PAIR_COND;
                        st_d.hold_op     = short_op[SLOT_L];
                        st_d.hold_tag    = TAG_CEXEC;
                    end else begin
                        st_d.out_tag     = TAG_LEFT;
                        st_d.out_payload = {{PAD_W{1'b0}}, short_op[SLOT_L]};
                        st_d.out_class   = short_class[SLOT_L];
                        st_d.mode        = PAIR_PAR;
                        st_d.hold_op     = short_op[SLOT_R];
                        st_d.hold_tag    = TAG_RIGHT;
                    end
                end
            endcase
        end else if (st_q.busy && fb_valid) begin
            logic go;
            st_d.busy = 1'b0;
            unique case (st_q.mode)
                PAIR_SEQ:  go = !fb_pc_changed && !fb_exception;
                PAIR_COND: go = fb_cond_true;
                default:   go = !fb_exception;
            endcase
            if (go) begin
                st_d.out_valid   = 1'b1;
                st_d.out_tag     = st_q.hold_tag;
                st_d.out_payload = {{PAD_W{1'b0}}, st_q.hold_op};
                st_d.out_class   = st_q.hold_op[CLASS_LO +: CLASS_W];
                cnt_step         = (st_q.mode == PAIR_SEQ);
            end else if (st_q.mode == PAIR_SEQ && !fb_exception) begin
                st_d.out_skip = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_ready  = !st_q.busy;
    assign iss_valid   = st_q.out_valid;
    assign iss_tag     = st_q.out_tag;
    assign iss_payload = st_q.out_payload;
    assign iss_class   = st_q.out_class;
    assign jump_skip   = st_q.out_skip;

    a_r1_long_single: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && word_data[31:30] == 2'b11)
        |=> (iss_valid && iss_tag == TAG_LONG && word_ready));

    a_r10_pair_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && word_data[31:30] != 2'b11)
        |=> (iss_valid && !word_ready));

    a_r6_cexec_after_true: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_tag == TAG_CEXEC) |-> $past(fb_valid && fb_cond_true));

    a_r5_skip_without_issue: assert property (@(posedge clk) disable iff (!rst_n)
        jump_skip |-> (!iss_valid && $past(fb_pc_changed && !fb_exception)));

    a_r12_second_needs_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(word_ready) && $past(rst_n)) |-> $past(fb_valid));

endmodule

// File: tb/sim_issue_sequencer.sv
module sim_issue_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic [31:0] word_data = '0;
    logic        fb_valid = 1'b0;
    logic        fb_pc_changed = 1'b0;
    logic        fb_exception = 1'b0;
    logic        fb_cond_true = 1'b0;
    logic        iss_valid;
    logic [2:0]  iss_tag;
    logic [29:0] iss_payload;
    logic [5:0]  iss_class;
    logic        jump_skip;
    logic [15:0] cyc_count;

    int errors = 0;
    int checks = 0;
    int exp_cnt = 0;

    localparam logic [2:0] T_LONG = 3'd0, T_LEFT = 3'd1, T_RIGHT = 3'd2,
                           T_CTEST = 3'd3, T_CEXEC = 3'd4;

    issue_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
        .word_data(word_data), .fb_valid(fb_valid), .fb_pc_changed(fb_pc_changed),
        .fb_exception(fb_exception), .fb_cond_true(fb_cond_true), .iss_valid(iss_valid),
        .iss_tag(iss_tag), .iss_payload(iss_payload), .iss_class(iss_class),
        .jump_skip(jump_skip), .cyc_count(cyc_count)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] mk(input logic [5:0] c, input logic [8:0] lo);
        return {c, lo};
    endfunction

    task automatic offer(input logic [31:0] w);
        word_valid = 1'b1;
        word_data  = w;
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic feedback(input logic pc, input logic ex, input logic ct);
        fb_valid = 1'b1; fb_pc_changed = pc; fb_exception = ex; fb_cond_true = ct;
        @(negedge clk);
        fb_valid = 1'b0; fb_pc_changed = 1'b0; fb_exception = 1'b0; fb_cond_true = 1'b0;
    endtask

    task automatic expect_issue(input string req, input logic [2:0] tag, input logic [14:0] op);
        check({req, " strobe"}, 32'(iss_valid), 32'd1);
        check({req, " tag"}, 32'(iss_tag), 32'(tag));
        check({req, " payload"}, 32'(iss_payload), 32'(op));
        check({req, " class"}, 32'(iss_class), 32'(op[14:9]));
    endtask

    task automatic settle(input string req);
        @(negedge clk);
        check({req, " strobe drops"}, 32'(iss_valid), 32'd0);
        check({req, " ready"}, 32'(word_ready), 32'd1);
        check({req, " count"}, 32'(cyc_count), 32'(exp_cnt));
    endtask

    task automatic t_reset();
        check("R11 ready", 32'(word_ready), 32'd1);
        check("R11 strobe", 32'(iss_valid), 32'd0);
        check("R11 count", 32'(cyc_count), 32'd0);
    endtask

    task automatic t_long();
        logic [29:0] p = 30'h1234_5678;
        offer({2'b11, p});
        exp_cnt++;
        check("R1 strobe", 32'(iss_valid), 32'd1);
        check("R1 tag", 32'(iss_tag), 32'(T_LONG));
        check("R1 payload", 32'(iss_payload), 32'(p));
        check("R1 class", 32'(iss_class), 32'h12);
        check("R1 ready", 32'(word_ready), 32'd1);
        check("R12 count", 32'(cyc_count), 32'(exp_cnt));
        settle("R1");
    endtask

    task automatic t_ordered(input logic rl);
        logic [14:0] l = mk(6'h05, 9'h011);
        logic [14:0] r = mk(6'h09, 9'h1F2);
        offer({rl ? 2'b10 : 2'b01, l, r});
        exp_cnt++;
        if (rl) expect_issue("R4 first", T_RIGHT, r);
        else    expect_issue("R3 first R2", T_LEFT, l);
        check("R10 busy", 32'(word_ready), 32'd0);
        feedback(1'b0, 1'b0, 1'b0);
        exp_cnt++;
        if (rl) expect_issue("R4 second", T_LEFT, l);
        else    expect_issue("R3 second R2", T_RIGHT, r);
        check("R9 seq count", 32'(cyc_count), 32'(exp_cnt));
        settle("R3/4");
    endtask

    task automatic t_seq_drop(input logic pc, input logic ex);
        offer({2'b01, mk(6'h01, 9'h0), mk(6'h02, 9'h3)});
        exp_cnt++;
        feedback(pc, ex, 1'b1);
        check("R5 no second", 32'(iss_valid), 32'd0);
        check("R5 jump skip", 32'(jump_skip), 32'(pc && !ex));
        check("R9 drop count", 32'(cyc_count), 32'(exp_cnt));
        settle("R5");
    endtask

    task automatic t_cond(input logic left_test, input logic both, input logic ct);
        logic [14:0] l = mk((left_test ? 6'h3A : 6'h07), 9'h0AA);
        logic [14:0] r = mk(((!left_test || both) ? 6'h3B : 6'h0C), 9'h155);
        offer({2'b00, l, r});
        exp_cnt++;
        if (left_test) expect_issue("R6 test", T_CTEST, l);
        else           expect_issue("R7 test", T_CTEST, r);
        feedback(1'b0, 1'b0, ct);
        if (ct) begin
            if (left_test) expect_issue("R6 exec", T_CEXEC, r);
            else           expect_issue("R7 exec", T_CEXEC, l);
        end else begin
            check("R6/R7 false drops", 32'(iss_valid), 32'd0);
        end
        check("R9 cond count", 32'(cyc_count), 32'(exp_cnt));
        settle("R6");
    endtask

    task automatic t_par(input logic pc, input logic ex);
        logic [14:0] l = mk(6'h10, 9'h001);
        logic [14:0] r = mk(6'h20, 9'h100);
        offer({2'b00, l, r});
        exp_cnt++;
        expect_issue("R8 left", T_LEFT, l);
        feedback(pc, ex, 1'b0);
        if (!ex) expect_issue("R8 right", T_RIGHT, r);
        else     check("R8 exception drops", 32'(iss_valid), 32'd0);
        check("R8 no skip", 32'(jump_skip), 32'd0);
        check("R9 par count", 32'(cyc_count), 32'(exp_cnt));
        settle("R8");
    endtask

    task automatic t_stall();
        logic [14:0] l = mk(6'h03, 9'h00F);
        logic [14:0] r = mk(6'h04, 9'h0F0);
        offer({2'b01, l, r});
        exp_cnt++;
        word_valid = 1'b1;
        word_data  = {2'b11, 30'h3FFF_FFFF};
        @(negedge clk);
        @(negedge clk);
        word_valid = 1'b0;
        check("R10 no issue in stall", 32'(iss_valid), 32'd0);
        check("R10 ready low", 32'(word_ready), 32'd0);
        feedback(1'b0, 1'b0, 1'b0);
        exp_cnt++;
        expect_issue("R10 pending second", T_RIGHT, r);
        settle("R10 stalled word not taken");
    endtask

    task automatic t_fb_idle();
        feedback(1'b1, 1'b0, 1'b1);
        check("R10 idle fb no issue", 32'(iss_valid), 32'd0);
        check("R10 idle fb no skip", 32'(jump_skip), 32'd0);
        check("R10 idle count", 32'(cyc_count), 32'(exp_cnt));
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long();
        t_ordered(1'b0);
        t_ordered(1'b1);
        t_seq_drop(1'b1, 1'b0);
        t_seq_drop(1'b1, 1'b1);
        t_seq_drop(1'b0, 1'b1);
        t_cond(1'b1, 1'b0, 1'b1);
        t_cond(1'b1, 1'b0, 1'b0);
        t_cond(1'b1, 1'b1, 1'b1);
        t_cond(1'b0, 1'b0, 1'b1);
        t_cond(1'b0, 1'b0, 1'b0);
        t_par(1'b1, 1'b0);
        t_par(1'b0, 1'b1);
        t_stall();
        t_fb_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule